// File: doc/BRIEF.md
# Digit-Serial Binary-Field Multiplier

This block multiplies two elements of GF(2^m), both in polynomial basis, and reduces the product modulo a fixed irreducible polynomial F(x). It uses the operand B a few bits at a time. Each clock cycle takes the next d-bit digit of B, starting with the most significant. It multiplies the running result by x^d, reduces it, and XORs in the digit times A. A full product therefore takes ceil(m/d) cycles. With d = 1 the block is a plain bit-serial multiplier.

A caller places A and B on the inputs and pulses `start` while the block is idle. Exactly ceil(m/d) cycles later, `done` pulses and `c_out` carries the product. The result stays on `c_out` until the next accepted start. F(x) is fixed when the block is built. It is given as its low-order terms: the x^m term is implied and not stored. When d does not divide m, B is padded with zeros above its top bit. The top digit is then partly empty, and the result is unchanged.

Top module: `gf_digit_mul`

## Requirements
- R1: After an accepted start, `c_out` equals A·B mod F(x), where F(x) = x^M + TAIL(x), field addition is bitwise XOR, and bit i of a bus is the coefficient of x^i.
- R2: Reduction folds an overflow past x^(M-1) back through TAIL. With M = 163 and TAIL = 'hC9, the product x^162 · x gives 'hC9.
- R3: B is consumed in S = ceil(M/D) digits, most significant digit first, with zero padding above bit M-1. For M = 163 and D = 5 this gives 33 digits and the correct product.
- R4: `done` is high in the clock cycle that follows the S-th rising edge after the edge that sampled the accepted start. For M = 163 and D = 8, that edge is the 21st.
- R5: `done` is high for exactly one cycle per accepted start.
- R6: `c_out` keeps its value from the `done` cycle until the next accepted start.
- R7: A `start` pulse that arrives while a product is in progress is ignored. The running product uses the original operands, and `done` still pulses only once, at the original time.
- R8: While reset is high and after it is released, `c_out` is zero and `done` is low.
- R9: With D = 1 the block works bit-serially and needs M = 163 cycles per product.
- R10: Multiplying by the field element 1 returns the other operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a product; accepted only while idle |
| a_in | input | M | Multiplicand A |
| b_in | input | M | Multiplier B, consumed one digit at a time |
| c_out | output | M | Product A·B mod F(x) |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
A wrong bit in the operand shift register or the accumulator does not go away. Through the later multiply-by-x steps it spreads into many coefficients, so any product computed with it differs from the reference by the time `done` rises, S cycles after start. An error in the step counter shows up directly at the ports: `done` arrives early or late, or pulses twice, in the same operation. Running the block with D = 8, 5 and 1 exercises full digits, a padded top digit and the bit-serial case.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    typedef enum logic {
        GFM_IDLE = 1'b0,
        GFM_RUN  = 1'b1
    } gfm_state_e;

    // Number of d-bit digits covering an m-bit operand
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/gfm_step.sv
// One digit step: acc_o = acc_i * x^D + dig_i * a_i  (mod F), Horner style.
module gfm_step #(
    parameter int          M    = 163,
    parameter int          D    = 8,
    parameter logic [M-1:0] TAIL = 'hC9
) (
    input  logic [M-1:0] acc_i,
    input  logic [M-1:0] a_i,
    input  logic [D-1:0] dig_i,
    output logic [M-1:0] acc_o
);

    logic [D:0][M-1:0] chain;

    assign chain[0] = acc_i;

    for (genvar g = 0; g < D; g++) begin : g_stage
        // multiply by x, fold x^M back through TAIL, add A if digit bit set
        assign chain[g+1] = {chain[g][M-2:0], 1'b0}
                          ^ (chain[g][M-1] ? TAIL : '0)
                          ^ (dig_i[D-1-g] ? a_i : '0);
    end

    assign acc_o = chain[D];

endmodule

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
    import gfm_pkg::*;
#(
    parameter int S = 21
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(S + 1);

    gfm_state_e    st;
    logic [CW-1:0] left;

    assign load_o = start_i && (st == GFM_IDLE);
    assign step_o = (st == GFM_RUN);
    assign busy_o = (st == GFM_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= GFM_IDLE;
            left   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st)
                GFM_IDLE: begin
                    if (start_i) begin
                        st   <= GFM_RUN;
                        left <= CW'(S);
                    end
                end
                GFM_RUN: begin
                    left <= left - CW'(1);
                    if (left == CW'(1)) begin
                        st     <= GFM_IDLE;
                        done_o <= 1'b1;
                    end
                end
                default: st <= GFM_IDLE;
            endcase
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3
    digit_count_chk: assert property (@(posedge clk) disable iff (rst)
        (st == GFM_RUN) |-> (left != '0 && left <= CW'(S)));

    // R4
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(busy_o));

endmodule

// File: rtl/gfm_opreg.sv
// Operand store: A held, B in a left-shifting register padded to S*D bits.
module gfm_opreg #(
    parameter int M = 163,
    parameter int D = 8,
    parameter int S = 21
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    output logic [M-1:0] a_q,
    output logic [D-1:0] dig_o
);

    localparam int W = S * D;

    logic [W-1:0] b_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            b_sr <= '0;
        end else if (load_i) begin
            a_q  <= a_i;
            b_sr <= W'(b_i);
        end else if (step_i) begin
            b_sr <= b_sr << D;
        end
    end

    assign dig_o = b_sr[W-1 -: D];

    // R7
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(a_q));

endmodule

// File: rtl/gf_digit_mul.sv
module gf_digit_mul
    import gfm_pkg::*;
#(
    parameter int           M    = 163,
    parameter int           D    = 8,
    parameter logic [M-1:0] TAIL = 'hC9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    output logic [M-1:0] c_out,
    output logic         done
);

    localparam int S = ceil_div(M, D);

    logic         load, step, busy;
    logic [M-1:0] a_q, acc_q, acc_d;
    logic [D-1:0] dig;

    gfm_ctrl #(.S(S)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start),
        .load_o(load), .step_o(step), .busy_o(busy), .done_o(done)
    );

    gfm_opreg #(.M(M), .D(D), .S(S)) u_opreg (
        .clk(clk), .rst(rst), .load_i(load), .step_i(step),
        .a_i(a_in), .b_i(b_in), .a_q(a_q), .dig_o(dig)
    );

    gfm_step #(.M(M), .D(D), .TAIL(TAIL)) u_step (
        .acc_i(acc_q), .a_i(a_q), .dig_i(dig), .acc_o(acc_d)
    );

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (load) acc_q <= '0;
        else if (step) acc_q <= acc_d;
    end

    assign c_out = acc_q;

    // R6
    c_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(c_out));

endmodule

// File: tb/gf_digit_mul_tb.sv
`timescale 1ns/1ps
module gf_digit_mul_tb;

    localparam int           M    = 163;
    localparam logic [M-1:0] TAIL = 'hC9;
    localparam int           NI   = 3;
    localparam int           NLOOP = 175;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [M-1:0] a_in = '0, b_in = '0;
    logic [M-1:0] cc [NI];
    logic [NI-1:0] dn;

    int checks = 0;
    int errors = 0;
    int lat [NI] = '{22, 164, 34}; // S+1 negedges after driving start

    always #2 clk = ~clk; // 250 MHz

    gf_digit_mul #(.M(M), .D(8), .TAIL(TAIL)) u_dut (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .c_out(cc[0]), .done(dn[0]));
    gf_digit_mul #(.M(M), .D(1), .TAIL(TAIL)) u_bit (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .c_out(cc[1]), .done(dn[1]));
    gf_digit_mul #(.M(M), .D(5), .TAIL(TAIL)) u_odd (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .c_out(cc[2]), .done(dn[2]));

    function automatic logic [M-1:0] mulref(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            logic top = r[M-1];
            r = r << 1;
            if (top) r = r ^ TAIL;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [M-1:0] rnd();
        logic [M-1:0] v = '0;
        for (int w = 0; w < 6; w++) v = (v << 32) | M'($urandom);
        return v;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one product on all three instances; optionally fires a stray start mid-run.
    task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b,
                          input logic [M-1:0] exp, input string vreq, input bit stray);
        int first [NI] = '{0, 0, 0};
        int npulse [NI] = '{0, 0, 0};
        logic [M-1:0] cap [NI];
        @(negedge clk);
        a_in = a; b_in = b; start = 1'b1;
        for (int n = 1; n <= NLOOP; n++) begin
            @(negedge clk);
            if (n == 1) start = 1'b0;
            if (stray && n == 4) begin a_in = ~a; b_in = b ^ 1; start = 1'b1; end
            if (stray && n == 5) start = 1'b0;
            for (int k = 0; k < NI; k++) begin
                if (dn[k]) begin
                    npulse[k]++;
                    if (first[k] == 0) begin first[k] = n; cap[k] = cc[k]; end
                end
            end
        end
        for (int k = 0; k < NI; k++) begin
            string lreq = (k == 1) ? "R9" : "R4";
            string rreq = (k == 2) ? "R3" : vreq;
            check(first[k] == lat[k], lreq, M'(first[k]), M'(lat[k]));
            check(npulse[k] == 1, "R5", M'(npulse[k]), M'(1));
            check(cap[k] === exp, rreq, cap[k], exp);
            check(cc[k] === cap[k], "R6", cc[k], cap[k]);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            check(cc[k] === '0, "R8", cc[k], '0);
            check(dn[k] === 1'b0, "R8", M'(dn[k]), '0);
        end
    endtask

    task automatic test_identity();
        logic [M-1:0] a = rnd();
        run_op(a, M'(1), a, "R10", 1'b0);
        run_op(M'(1), a, a, "R10", 1'b0);
    endtask

    task automatic test_reduce();
        run_op(M'(1) << (M - 1), M'(2), TAIL, "R2", 1'b0);
    endtask

    task automatic test_random();
        for (int t = 0; t < 4; t++) begin
            logic [M-1:0] a = rnd();
            logic [M-1:0] b = rnd();
            run_op(a, b, mulref(a, b), "R1", 1'b0);
            run_op(b, a, mulref(a, b), "R1", 1'b0);
        end
    endtask

    task automatic test_all_ones();
        run_op('1, '1, mulref('1, '1), "R1", 1'b0);
    endtask

    task automatic test_stray_start();
        logic [M-1:0] a = rnd();
        logic [M-1:0] b = rnd();
        run_op(a, b, mulref(a, b), "R7", 1'b1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        test_reset();
        test_identity();
        test_reduce();
        test_random();
        test_all_ones();
        test_stray_start();
        finish_run();
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule